// File: doc/BRIEF.md
# Omega Multistage Interconnection Network

This block joins a set of requesters to the same number of memory banks through a self-routing omega network. The port count is a power-of-two parameter. The network has one stage for each address bit. Each stage first permutes the lanes with a perfect shuffle and then passes them through a column of two-by-two switches. A switch sets itself to straight or crossed from one bit of each request's destination address, so no central arbiter is involved.

Each input carries a valid flag, a destination bank number and a payload. Each output shows whether a request arrived, which input sent it, and its payload. The network can block. When two requests need the same output of a switch, the request on the switch's lower-numbered input goes on. The other request is dropped, and a per-input blocked flag reports it. The block does not queue, retry or apply back-pressure; the requester decides what to do about a blocked request. A parameter selects one register stage on all outputs (the default) or a purely combinational path.

Top module: `omega_net`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output valid flag and every blocked flag reads 0, whatever the inputs are.
- R2: With the output register enabled, a request presented in one cycle appears at output `dest` after the next rising clock edge. It carries its payload unchanged, and its source field equals its input index.
- R3: In front of every stage, lane i moves to lane 2i when i < p/2 and to lane 2i+1-p otherwise.
- R4: At stage k, counting from 0, a switch sends a request to its even (upper) output lane when destination bit log2(p)-1-k is 0, and to its odd (lower) lane when that bit is 1. As a result, every delivered request leaves at output index `dest`.
- R5: When both requests at a switch want the same output, the request on the even input lane goes on. The request on the odd lane is dropped from every output, and its blocked flag is set.
- R6: An input whose valid flag is 0 produces no output and never raises its blocked flag. Its destination and payload have no effect on any output.
- R7: Every valid input is either delivered to exactly one output or flagged blocked, never both.
- R8: A request set that no switch contends for, such as the identity mapping or a uniform cyclic shift of destinations, is delivered completely with no blocked flags.
- R9: The route from input 2 to output 7 (p = 8) blocks a simultaneous request from input 6 whose destination is 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NPORTS | Request present, one bit per input |
| in_dest | input | NPORTS*log2(NPORTS) | Destination bank per input, input i in slice i |
| in_data | input | NPORTS*DATA_W | Payload per input |
| out_valid | output | NPORTS | A request reached this output |
| out_src | output | NPORTS*log2(NPORTS) | Index of the input delivered to each output |
| out_data | output | NPORTS*DATA_W | Payload delivered to each output |
| in_blocked | output | NPORTS | Request from this input lost a switch conflict |

## Verification
The first pattern is one request at a time, swept over every input and destination pair; it shows that the shuffle wiring and the bit-by-bit steering deliver to the right bank. The identity mapping and cyclic shifts are conflict-free sets and show that full loads pass untouched. Patterns that aim every input at a single bank, together with the 2-to-7 example, expose the tie-break and tell even-lane priority apart from odd-lane priority. Pseudo-random partial patterns with junk on invalid lanes are compared against a reference that derives each lane's position arithmetically from source and destination bits. These show that nothing is lost or duplicated and that idle inputs stay silent.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Lane index that lane i moves to in front of every stage
  function automatic int unsigned shuffle_idx(input int unsigned i, input int unsigned n);
    return (i < n / 2) ? 2 * i : 2 * i + 1 - n;
  endfunction

  // Destination bit that steers the switches of a given stage
  function automatic int unsigned steer_bit(input int unsigned stage, input int unsigned aw);
    return aw - 1 - stage;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int AW  = 3,
  parameter int DW  = 8,
  parameter int BIT = 2
) (
  input  logic          a_v,
  input  logic [AW-1:0] a_dst,
  input  logic [AW-1:0] a_src,
  input  logic [DW-1:0] a_dat,
  input  logic          b_v,
  input  logic [AW-1:0] b_dst,
  input  logic [AW-1:0] b_src,
  input  logic [DW-1:0] b_dat,
  output logic          u_v,
  output logic [AW-1:0] u_dst,
  output logic [AW-1:0] u_src,
  output logic [DW-1:0] u_dat,
  output logic          l_v,
  output logic [AW-1:0] l_dst,
  output logic [AW-1:0] l_src,
  output logic [DW-1:0] l_dat,
  output logic          b_lost
);

  logic a_low, b_low;

  assign a_low  = a_dst[BIT];
  assign b_low  = b_dst[BIT];
  // the even input always wins a tie
  assign b_lost = a_v & b_v & (a_low == b_low);

  always_comb begin
    u_v = 1'b0; u_dst = a_dst; u_src = a_src; u_dat = a_dat;
    if (a_v && !a_low) begin
      u_v = 1'b1;
    end else if (b_v && !b_low) begin
      u_v = 1'b1; u_dst = b_dst; u_src = b_src; u_dat = b_dat;
    end
  end

  always_comb begin
    l_v = 1'b0; l_dst = a_dst; l_src = a_src; l_dat = a_dat;
    if (a_v && a_low) begin
      l_v = 1'b1;
    end else if (b_v && b_low) begin
      l_v = 1'b1; l_dst = b_dst; l_src = b_src; l_dat = b_dat;
    end
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int N     = 8,
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int STAGE = 0
) (
  input  logic [N-1:0]         in_v,
  input  logic [N-1:0][AW-1:0] in_dst,
  input  logic [N-1:0][AW-1:0] in_src,
  input  logic [N-1:0][DW-1:0] in_dat,
  output logic [N-1:0]         out_v,
  output logic [N-1:0][AW-1:0] out_dst,
  output logic [N-1:0][AW-1:0] out_src,
  output logic [N-1:0][DW-1:0] out_dat,
  output logic [N-1:0]         drop_src
);

  localparam int NSW   = N / 2;
  localparam int BITSEL = int'(steer_bit(STAGE, AW));

  logic [N-1:0]         sh_v;
  logic [N-1:0][AW-1:0] sh_dst;
  logic [N-1:0][AW-1:0] sh_src;
  logic [N-1:0][DW-1:0] sh_dat;
  logic [NSW-1:0]       sw_lost;

  // perfect shuffle wiring (R3)
  for (genvar i = 0; i < N; i++) begin : g_shuf
    localparam int P = int'(shuffle_idx(i, N));
    assign sh_v[P]   = in_v[i];
    assign sh_dst[P] = in_dst[i];
    assign sh_src[P] = in_src[i];
    assign sh_dat[P] = in_dat[i];
  end

  // column of 2x2 switches
  for (genvar j = 0; j < NSW; j++) begin : g_sw
    omega_switch #(.AW(AW), .DW(DW), .BIT(BITSEL)) i_sw (
      .a_v   (sh_v[2*j]),     .a_dst (sh_dst[2*j]),
      .a_src (sh_src[2*j]),   .a_dat (sh_dat[2*j]),
      .b_v   (sh_v[2*j+1]),   .b_dst (sh_dst[2*j+1]),
      .b_src (sh_src[2*j+1]), .b_dat (sh_dat[2*j+1]),
      .u_v   (out_v[2*j]),    .u_dst (out_dst[2*j]),
      .u_src (out_src[2*j]),  .u_dat (out_dat[2*j]),
      .l_v   (out_v[2*j+1]),  .l_dst (out_dst[2*j+1]),
      .l_src (out_src[2*j+1]),.l_dat (out_dat[2*j+1]),
      .b_lost(sw_lost[j])
    );
  end

  // losers are reported by their original input index
  always_comb begin
    drop_src = '0;
    for (int j = 0; j < NSW; j++) begin
      if (sw_lost[j]) drop_src[sh_src[2*j+1]] = 1'b1;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int NPORTS  = 8,
  parameter int DATA_W  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NPORTS-1:0]                 in_valid,
  input  logic [NPORTS*$clog2(NPORTS)-1:0]  in_dest,
  input  logic [NPORTS*DATA_W-1:0]          in_data,
  output logic [NPORTS-1:0]                 out_valid,
  output logic [NPORTS*$clog2(NPORTS)-1:0]  out_src,
  output logic [NPORTS*DATA_W-1:0]          out_data,
  output logic [NPORTS-1:0]                 in_blocked
);

  localparam int AW     = $clog2(NPORTS);
  localparam int STAGES = AW;

  logic [NPORTS-1:0]             st_v   [STAGES+1];
  logic [NPORTS-1:0][AW-1:0]     st_dst [STAGES+1];
  logic [NPORTS-1:0][AW-1:0]     st_src [STAGES+1];
  logic [NPORTS-1:0][DATA_W-1:0] st_dat [STAGES+1];
  logic [NPORTS-1:0]             st_drop[STAGES];

  // named internal events for checking
  logic [NPORTS-1:0] drop_any;
  logic [NPORTS-1:0] landed;

  for (genvar i = 0; i < NPORTS; i++) begin : g_in
    assign st_v[0][i]   = in_valid[i];
    assign st_dst[0][i] = in_dest[i*AW +: AW];
    assign st_src[0][i] = AW'(i);
    assign st_dat[0][i] = in_data[i*DATA_W +: DATA_W];
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    omega_stage #(.N(NPORTS), .AW(AW), .DW(DATA_W), .STAGE(k)) i_stage (
      .in_v    (st_v[k]),   .in_dst (st_dst[k]),
      .in_src  (st_src[k]), .in_dat (st_dat[k]),
      .out_v   (st_v[k+1]), .out_dst(st_dst[k+1]),
      .out_src (st_src[k+1]), .out_dat(st_dat[k+1]),
      .drop_src(st_drop[k])
    );

    AST_STAGE_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(st_v[k]) == $countones(st_v[k+1]) + $countones(st_drop[k])); // R7
  end

  always_comb begin
    drop_any = '0;
    for (int k = 0; k < STAGES; k++) drop_any |= st_drop[k];
  end

  always_comb begin
    landed = '0;
    for (int o = 0; o < NPORTS; o++) begin
      if (st_v[STAGES][o]) landed[st_src[STAGES][o]] = 1'b1;
    end
  end

  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    AST_LAND_AT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      st_v[STAGES][i] |-> (st_dst[STAGES][i] == AW'(i))); // R4
    AST_ONE_FATE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[i] |-> (landed[i] != drop_any[i])); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[i] |-> (!landed[i] && !drop_any[i])); // R6
  end

  logic [NPORTS-1:0]          fin_v;
  logic [NPORTS*AW-1:0]       fin_src;
  logic [NPORTS*DATA_W-1:0]   fin_dat;

  for (genvar o = 0; o < NPORTS; o++) begin : g_fin
    assign fin_v[o]                    = st_v[STAGES][o];
    assign fin_src[o*AW +: AW]         = st_src[STAGES][o];
    assign fin_dat[o*DATA_W +: DATA_W] = st_dat[STAGES][o];
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid  <= '0;
        out_src    <= '0;
        out_data   <= '0;
        in_blocked <= '0;
      end else begin
        out_valid  <= fin_v;
        out_src    <= fin_src;
        out_data   <= fin_dat;
        in_blocked <= drop_any;
      end
    end

    for (genvar i = 0; i < NPORTS; i++) begin : g_rchk
      AST_BLOCK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_blocked[i] |-> $past(in_valid[i])); // R6
    end
  end else begin : g_comb
    assign out_valid  = fin_v;
    assign out_src    = fin_src;
    assign out_data   = fin_dat;
    assign in_blocked = drop_any;
  end

endmodule

// File: tb/test_omega_net.sv
module test_omega_net;

  localparam int NP = 8;
  localparam int AW = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    in_valid = '0;
  logic [NP*AW-1:0] in_dest  = '0;
  logic [NP*DW-1:0] in_data  = '0;
  logic [NP-1:0]    out_valid;
  logic [NP*AW-1:0] out_src;
  logic [NP*DW-1:0] out_data;
  logic [NP-1:0]    in_blocked;

  always #10 clk = ~clk; // 50 MHz

  omega_net #(.NPORTS(NP), .DATA_W(DW), .OUT_REG(1'b1)) i_omega_net (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_src(out_src),
    .out_data(out_data), .in_blocked(in_blocked)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int unsigned rng = 32'h1234_5678;

  logic          pv  [NP];
  int            pd  [NP];
  logic [DW-1:0] pdat[NP];
  logic          ev  [NP];
  int            es  [NP];
  logic          eblk[NP];

  function automatic int unsigned next_rand();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference: after stage k a request sits at lane
  // ((src << (k+1)) | (dest >> (AW-1-k))) mod NP; on a clash the one whose
  // source bit AW-1-k is 0 came in on the even lane and survives.
  task automatic ref_model();
    logic alive[NP];
    int   pos[NP];
    for (int s = 0; s < NP; s++) begin
      alive[s] = pv[s]; eblk[s] = 1'b0; ev[s] = 1'b0; es[s] = 0;
    end
    for (int k = 0; k < AW; k++) begin
      for (int s = 0; s < NP; s++)
        pos[s] = ((s << (k + 1)) | (pd[s] >> (AW - 1 - k))) % NP;
      for (int s = 0; s < NP; s++) begin
        for (int t = s + 1; t < NP; t++) begin
          if (alive[s] && alive[t] && pos[s] == pos[t]) begin
            if (((s >> (AW - 1 - k)) & 1) == 1) begin
              alive[s] = 1'b0; eblk[s] = 1'b1;
            end else begin
              alive[t] = 1'b0; eblk[t] = 1'b1;
            end
          end
        end
      end
    end
    for (int s = 0; s < NP; s++) begin
      if (alive[s]) begin ev[pd[s]] = 1'b1; es[pd[s]] = s; end
    end
  endtask

  task automatic run_pattern(input string tag);
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      in_valid[i]          = pv[i];
      in_dest[i*AW +: AW]  = AW'(pd[i]);
      in_data[i*DW +: DW]  = pdat[i];
    end
    ref_model();
    @(negedge clk);
    for (int o = 0; o < NP; o++) begin
      check(tag, $sformatf("out_valid[%0d]", o), int'(out_valid[o]), int'(ev[o]));
      if (ev[o]) begin
        check(tag, $sformatf("out_src[%0d]", o), int'(out_src[o*AW +: AW]), es[o]);
        check(tag, $sformatf("out_data[%0d]", o), int'(out_data[o*DW +: DW]),
              int'(pdat[es[o]]));
      end
    end
    for (int i = 0; i < NP; i++)
      check(tag, $sformatf("in_blocked[%0d]", i), int'(in_blocked[i]), int'(eblk[i]));
  endtask

  task automatic clear_pattern();
    for (int i = 0; i < NP; i++) begin
      pv[i] = 1'b0; pd[i] = 0; pdat[i] = DW'(8'h5A ^ (i * 37));
    end
  endtask

  // R1: outputs stay quiet through reset and the first cycle after
  task automatic t_reset();
    in_valid = '1; in_dest = '0; in_data = '1;
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "in_blocked in reset", int'(in_blocked), 0);
    rst_n = 1'b1;
    in_valid = '0;
    @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "in_blocked after reset", int'(in_blocked), 0);
  endtask

  // R2 R3 R4: every single source to every destination
  task automatic t_single_sweep();
    for (int s = 0; s < NP; s++) begin
      for (int d = 0; d < NP; d++) begin
        clear_pattern();
        pv[s] = 1'b1; pd[s] = d; pdat[s] = DW'(s * 16 + d + 1);
        run_pattern("R2_R3_R4 single");
      end
    end
  endtask

  // R8: conflict-free full loads
  task automatic t_perms();
    for (int sh = 0; sh < NP; sh++) begin
      clear_pattern();
      for (int i = 0; i < NP; i++) begin pv[i] = 1'b1; pd[i] = (i + sh) % NP; end
      run_pattern("R8 shift");
      for (int i = 0; i < NP; i++)
        check("R8", $sformatf("no block shift %0d in %0d", sh, i), int'(in_blocked[i]), 0);
    end
  endtask

  // R5: all inputs to one bank; only input 0 survives
  task automatic t_hotspot();
    for (int d = 0; d < NP; d++) begin
      clear_pattern();
      for (int i = 0; i < NP; i++) begin pv[i] = 1'b1; pd[i] = d; end
      run_pattern("R5 hotspot");
      check("R5", "hotspot winner src", int'(out_src[d*AW +: AW]), 0);
      check("R5", "hotspot blocked count", $countones(in_blocked), NP - 1);
    end
  endtask

  // R9: 2->7 blocks 6 when 6 heads for the upper half
  task automatic t_doc_block();
    for (int d = 4; d < NP; d++) begin
      clear_pattern();
      pv[2] = 1'b1; pd[2] = 7;
      pv[6] = 1'b1; pd[6] = d;
      run_pattern("R9 route 2-7");
      check("R9", "input 6 blocked", int'(in_blocked[6]), 1);
      check("R9", "output 7 source", int'(out_src[7*AW +: AW]), 2);
    end
    clear_pattern();
    pv[2] = 1'b1; pd[2] = 7; pv[6] = 1'b1; pd[6] = 1;
    run_pattern("R9 no clash");
    check("R9", "input 6 delivered", int'(out_valid[1]), 1);
  endtask

  // R6: invalid lanes carry junk that must not matter
  task automatic t_invalid_junk();
    clear_pattern();
    for (int i = 0; i < NP; i++) pd[i] = 0;
    pv[5] = 1'b1; pd[5] = 3; pdat[5] = 8'hC3;
    run_pattern("R6 junk");
    check("R6", "blocked only none", int'(in_blocked), 0);
    check("R6", "single output", $countones(out_valid), 1);
    clear_pattern();
    for (int i = 0; i < NP; i++) pd[i] = 3;
    run_pattern("R6 idle");
    check("R6", "no outputs idle", int'(out_valid), 0);
  endtask

  // R5 R7: pseudo-random partial loads
  task automatic t_random();
    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < NP; i++) begin
        int unsigned r;
        r = next_rand();
        pv[i] = r[0] | r[1];
        pd[i] = int'(r[6:4]);
        pdat[i] = r[15:8];
      end
      run_pattern("R5_R7 random");
      for (int i = 0; i < NP; i++) begin
        logic seen;
        seen = 1'b0;
        for (int o = 0; o < NP; o++)
          if (out_valid[o] && int'(out_src[o*AW +: AW]) == i) seen = 1'b1;
        check("R7", $sformatf("single fate in %0d", i),
              int'(seen) + int'(in_blocked[i]), int'(pv[i]));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_pattern();
    t_reset();
    t_single_sweep();
    t_perms();
    t_hotspot();
    t_doc_block();
    t_invalid_junk();
    t_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule